// File: doc/BRIEF.md
# Variable-pulse-width frame transmitter

This block sends one frame at a time on a single-wire bus that uses variable-pulse-width coding. The host hands over bytes through a valid/ready handshake and flags the final byte. The block then drives the frame on its own. It opens the frame with an active start symbol and shifts each byte out MSB first. It closes the data with a computed check byte and then holds the line passive through the end-of-data and end-of-frame gaps. The width of every symbol depends on both the bit value and the bus level driven during it. The driven level flips at every symbol boundary.

A frame can carry an in-frame response. The response type is sampled together with the first byte. After the end-of-data gap, the block drives a normalization symbol and then sends the response bytes that the host supplies after the main frame's final byte. Type 3 responses carry their own check byte; types 1 and 2 carry none. While a passive data symbol is on the line, the block compares the line it reads back with the level it drives. If another node holds the line active, the block drops off the bus at once and reports that it lost arbitration.

All symbol widths count a timebase tick, normally one per microsecond. They are parameters. Bus level 1 means active and 0 means passive.

Top module: `vpw_tx`

## Requirements
- R1: After reset, `bus_out` is 0 (passive), `in_ready` is 1, and `done` and `lost_arb` are 0.
- R2: The clock edge that accepts a byte while idle starts the start-of-frame symbol: active for T_SOF (200) ticks. The host never supplies this symbol.
- R3: Data bits go out MSB first, and each symbol inverts the level of the one before. The first bit after start-of-frame is passive. A symbol lasts T_LONG (128) ticks when bit XOR level is 1, otherwise T_SHORT (64). So 0 is passive-short or active-long, and 1 is passive-long or active-short.
- R4: After the byte flagged last, a check byte follows and is encoded the same way. It is the complement of a CRC-8 register. The register uses polynomial 0x1D, is preset to 0xFF and takes the data bits MSB first.
- R5: After the last check byte (or the last byte of a type 1 or 2 response), the line stays passive for T_EOD (200) ticks and then for T_EOF (280) more ticks. `done` then pulses for one cycle and the block returns to idle.
- R6: `ifr_type` is sampled with the first byte; 0 means no response. For a nonzero type, the end-of-data gap is followed by an active normalization symbol: T_LONG for type 3, T_SHORT for types 1 and 2. Then comes the response byte stream. Type 3 appends a check byte computed afresh over the response bytes; types 1 and 2 append none.
- R7: `in_ready` is 1 while idle. During a frame it is 1 only while the one-byte holding register is empty and the host still owes a byte flagged last. It is 1 again once the frame ends.
- R8: If `bus_in` reads active when a passive data-bit symbol ends, the block does three things. It sets `lost_arb`, drives passive from the next cycle, and returns to idle without a `done` pulse. `lost_arb` stays set until the next frame's first byte is accepted.
- R9: Symbol widths count only cycles with `tick` high. Outside idle, the line does not change in a cycle that follows one without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase pulse, one cycle wide |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Host byte |
| in_last | input | 1 | Byte ends the current stream (main or response) |
| ifr_type | input | 2 | Response type, sampled with the first byte |
| bus_in | input | 1 | Sampled bus level, 1 = active |
| bus_out | output | 1 | Driven bus level, 1 = active |
| lost_arb | output | 1 | Arbitration lost, held until the next frame |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The assertions take several things about the inputs for granted. `tick` is a single-cycle pulse. `bus_in` echoes `bus_out` except while another node drives the line active. `ifr_type` is steady when the first byte is offered. The host always has the next byte available before the current byte's last symbol ends, so the line is never stretched while waiting. The stimulus keeps to these conditions: it offers every byte as soon as `in_ready` allows, and it models the line as the OR of the block's own output and a contender. It checks each frame run by run against widths derived from the requirements. It also runs one frame with a tick every other cycle.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF, ST_BIT, ST_WAIT, ST_EOD, ST_NB, ST_EOF
  } tx_state_t;

  // One serial CRC step, data bit entering at the top
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

endpackage

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] len_in,
  output logic          expire
);
  logic [CW-1:0] cnt, len;
  logic          run;

  assign expire = run && tick && (cnt == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      len <= len_in;
      run <= 1'b1;
    end else if (expire) begin
      run <= 1'b0;
    end else if (run && tick) begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len)); // R9

endmodule

// File: rtl/vpw_crc8.sv
module vpw_crc8
  import vpw_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       shift,
  input  logic       bit_in,
  output logic [7:0] crc,
  output logic [7:0] crc_nx
);
  assign crc_nx = crc8_step(crc, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_SEED;
    else if (init)  crc <= CRC_SEED;
    else if (shift) crc <= crc_nx;
  end
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_tx_pkg::*;
#(
  parameter int T_SHORT = 64,
  parameter int T_LONG  = 128,
  parameter int T_SOF   = 200,
  parameter int T_EOD   = 200,
  parameter int T_EOF   = 280
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [1:0] ifr_type,
  input  logic       bus_in,
  output logic       bus_out,
  output logic       lost_arb,
  output logic       done
);
  localparam int TM1  = (T_LONG > T_SOF) ? T_LONG : T_SOF;
  localparam int TM2  = (TM1 > T_EOD) ? TM1 : T_EOD;
  localparam int TMAX = (TM2 > T_EOF) ? TM2 : T_EOF;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] L_SHORT = CW'(T_SHORT);
  localparam logic [CW-1:0] L_LONG  = CW'(T_LONG);
  localparam logic [CW-1:0] L_SOF   = CW'(T_SOF);
  localparam logic [CW-1:0] L_EOD   = CW'(T_EOD);
  localparam logic [CW-1:0] L_EOF   = CW'(T_EOF);

  function automatic logic [CW-1:0] bit_len(input logic b, input logic lvl);
    return (b ^ lvl) ? L_LONG : L_SHORT;
  endfunction

  tx_state_t     st, st_n;
  logic          level, level_n;
  logic [7:0]    sh, sh_n;
  logic [2:0]    bc, bc_n;
  logic          cur_last, cur_last_n;
  logic          crc_phase, crc_phase_n;
  logic          resp, resp_n;
  logic [1:0]    ifr_q, ifr_q_n;
  logic          hold_v, hold_v_n;
  logic [7:0]    hold_d;
  logic          hold_l;
  logic [1:0]    lasts, lasts_n;
  logic          lost_q, lost_n;
  logic          done_q, done_n;
  logic          want_next;

  // named internal events
  logic          sym_end, accept, arb_lose, crc_shift, crc_init, tmr_start;
  logic [CW-1:0] tmr_len;
  logic [7:0]    crc_q, crc_nx;
  logic [1:0]    lasts_need;

  vpw_sym_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(tmr_start), .len_in(tmr_len), .expire(sym_end)
  );

  vpw_crc8 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .shift(crc_shift),
    .bit_in(sh[7]), .crc(crc_q), .crc_nx(crc_nx)
  );

  assign lasts_need = (ifr_q != 2'd0) ? 2'd2 : 2'd1;
  assign in_ready   = (st == ST_IDLE) || (!hold_v && (lasts < lasts_need));
  assign accept     = in_valid && in_ready;
  assign arb_lose   = sym_end && (st == ST_BIT) && !level && bus_in;
  assign crc_shift  = sym_end && (st == ST_BIT) && !arb_lose && !crc_phase;
  assign bus_out    = level;
  assign lost_arb   = lost_q;
  assign done       = done_q;

  always_comb begin
    st_n = st; level_n = level; sh_n = sh; bc_n = bc;
    cur_last_n = cur_last; crc_phase_n = crc_phase; resp_n = resp;
    ifr_q_n = ifr_q; hold_v_n = hold_v; lasts_n = lasts;
    lost_n = lost_q; done_n = 1'b0; want_next = 1'b0;
    tmr_start = 1'b0; tmr_len = '0; crc_init = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        st_n = ST_SOF; level_n = 1'b1; tmr_start = 1'b1; tmr_len = L_SOF;
        sh_n = in_data; cur_last_n = in_last; ifr_q_n = ifr_type;
        resp_n = 1'b0; crc_phase_n = 1'b0; crc_init = 1'b1; lost_n = 1'b0;
        lasts_n = in_last ? 2'd1 : 2'd0; hold_v_n = 1'b0;
      end
      ST_SOF: if (sym_end) begin
        st_n = ST_BIT; level_n = 1'b0; bc_n = '0;
        tmr_start = 1'b1; tmr_len = bit_len(sh[7], 1'b0);
      end
      ST_BIT: if (sym_end) begin
        if (arb_lose) begin
          st_n = ST_IDLE; level_n = 1'b0; lost_n = 1'b1; hold_v_n = 1'b0;
        end else begin
          level_n = ~level;
          if (bc != 3'd7) begin
            sh_n = {sh[6:0], 1'b0}; bc_n = bc + 3'd1;
            tmr_start = 1'b1; tmr_len = bit_len(sh[6], ~level);
          end else if (crc_phase) begin
            crc_phase_n = 1'b0; st_n = ST_EOD; tmr_start = 1'b1; tmr_len = L_EOD;
          end else if (cur_last && (!resp || ifr_q == 2'd3)) begin
            crc_phase_n = 1'b1; sh_n = ~crc_nx; bc_n = '0;
            tmr_start = 1'b1; tmr_len = bit_len(~crc_nx[7], ~level);
          end else if (cur_last) begin
            st_n = ST_EOD; tmr_start = 1'b1; tmr_len = L_EOD;
          end else begin
            want_next = 1'b1;
          end
        end
      end
      ST_WAIT: want_next = hold_v;
      ST_EOD: if (sym_end) begin
        if (!resp && ifr_q != 2'd0) begin
          st_n = ST_NB; level_n = 1'b1; resp_n = 1'b1; crc_init = 1'b1;
          tmr_start = 1'b1; tmr_len = (ifr_q == 2'd3) ? L_LONG : L_SHORT;
        end else begin
          st_n = ST_EOF; tmr_start = 1'b1; tmr_len = L_EOF;
        end
      end
      ST_NB: if (sym_end) begin
        level_n = 1'b0; want_next = 1'b1;
      end
      ST_EOF: if (sym_end) begin
        st_n = ST_IDLE; done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
    if (want_next) begin
      if (hold_v) begin
        st_n = ST_BIT; sh_n = hold_d; cur_last_n = hold_l; hold_v_n = 1'b0;
        bc_n = '0; tmr_start = 1'b1; tmr_len = bit_len(hold_d[7], level_n);
      end else begin
        st_n = ST_WAIT;
      end
    end
    if (accept && st != ST_IDLE) begin
      hold_v_n = 1'b1;
      if (in_last) lasts_n = lasts + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; level <= 1'b0; sh <= '0; bc <= '0;
      cur_last <= 1'b0; crc_phase <= 1'b0; resp <= 1'b0; ifr_q <= '0;
      hold_v <= 1'b0; hold_d <= '0; hold_l <= 1'b0; lasts <= '0;
      lost_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st <= st_n; level <= level_n; sh <= sh_n; bc <= bc_n;
      cur_last <= cur_last_n; crc_phase <= crc_phase_n; resp <= resp_n;
      ifr_q <= ifr_q_n; hold_v <= hold_v_n; lasts <= lasts_n;
      lost_q <= lost_n; done_q <= done_n;
      if (accept && st != ST_IDLE) begin
        hold_d <= in_data;
        hold_l <= in_last;
      end
    end
  end

  AST_SOF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SOF) |-> bus_out); // R2
  AST_BIT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_end && st == ST_BIT && !arb_lose) |=> (bus_out != $past(bus_out))); // R3
  AST_GAP_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EOD || st == ST_EOF) |-> !bus_out); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_NB_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NB) |-> bus_out); // R6
  AST_LOSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lose |=> (!bus_out && lost_arb && in_ready && !done)); // R8
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st != ST_IDLE) |=> $stable(bus_out)); // R9

endmodule

// File: tb/sim_vpw_tx.sv
module sim_vpw_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic tick_half = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic [1:0] ifr_type = '0;
  logic contend = 1'b0;
  logic in_ready, bus_out, lost_arb, done;
  logic bus_in;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= tick_half ? ~tick : 1'b1;
  assign bus_in = bus_out | contend;

  vpw_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .ifr_type(ifr_type), .bus_in(bus_in), .bus_out(bus_out),
    .lost_arb(lost_arb), .done(done)
  );

  localparam int NV = 5;
  localparam logic [1:0]  V_IFR  [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam int          V_NM   [NV] = '{1, 4, 3, 2, 3};
  localparam logic [31:0] V_MAIN [NV] = '{32'h55000000, 32'h686AF13C,
                                          32'h486B1000, 32'hFF000000, 32'h6C10F100};
  localparam int          V_NR   [NV] = '{0, 0, 1, 1, 2};
  localparam logic [15:0] V_RESP [NV] = '{16'h0000, 16'h0000, 16'hA500,
                                          16'h3C00, 16'h12EE};

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int exp_lvl [100], exp_len [100], exp_reg [100];
  int exp_n;
  int rec_lvl [100], rec_len [100];
  int rec_n = 0, done_cnt = 0, mon_run = 0;
  logic mon_prev = 1'b0;
  logic bl;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // run-length monitor of the driven line
  always @(negedge clk) begin
    if (done) begin
      if (rec_n < 100) begin rec_lvl[rec_n] = int'(mon_prev); rec_len[rec_n] = mon_run; end
      rec_n++; done_cnt++; mon_run = 0;
    end else if (bus_out != mon_prev) begin
      if (mon_run > 0) begin
        if (rec_n < 100) begin rec_lvl[rec_n] = int'(mon_prev); rec_len[rec_n] = mon_run; end
        rec_n++;
      end
      mon_prev = bus_out; mon_run = 1;
    end else if (mon_run > 0) begin
      if (lost_arb) mon_run = 0; else mon_run++;
    end
  end

  function automatic logic [7:0] ref_crc(input logic [31:0] bytes, input int n);
    logic [7:0] c = 8'hFF;
    for (int j = 0; j < n; j++) begin
      c = c ^ bytes[31-8*j -: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return c;
  endfunction

  task automatic push(input int lvl, input int len, input int rg);
    exp_lvl[exp_n] = lvl; exp_len[exp_n] = len; exp_reg[exp_n] = rg; exp_n++;
  endtask

  task automatic add_byte(input logic [7:0] b, input int rg);
    for (int k = 7; k >= 0; k--) begin
      push(int'(bl), (b[k] != bl) ? 128 : 64, rg);
      bl = ~bl;
    end
  endtask

  task automatic build(input int i);
    exp_n = 0;
    push(1, 200, 0);
    bl = 1'b0;
    for (int j = 0; j < V_NM[i]; j++) add_byte(V_MAIN[i][31-8*j -: 8], 1);
    add_byte(~ref_crc(V_MAIN[i], V_NM[i]), 2);
    if (V_IFR[i] != 2'd0) begin
      push(0, 200, 3);
      push(1, (V_IFR[i] == 2'd3) ? 128 : 64, 4);
      bl = 1'b0;
      for (int j = 0; j < V_NR[i]; j++) add_byte(V_RESP[i][15-8*j -: 8], 5);
      if (V_IFR[i] == 2'd3) add_byte(~ref_crc({V_RESP[i], 16'h0}, V_NR[i]), 2);
    end
    push(0, 480, 3);
  endtask

  function automatic string tag(input int r);
    case (r)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input int scale);
    chk(rec_n == exp_n, "R3", "symbol count", rec_n, exp_n);
    chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
    for (int r = 0; r < 6; r++) begin
      bit present = 1'b0, bad = 1'b0;
      int ba = 0, be = 0;
      for (int k = 0; k < exp_n; k++) begin
        if (exp_reg[k] == r) begin
          int el = exp_len[k] * scale;
          int al = (k < rec_n) ? rec_len[k] : -1;
          bit ok;
          present = 1'b1;
          ok = (k < rec_n) && (rec_lvl[k] == exp_lvl[k]) &&
               ((al == el) || (k == 0 && scale == 2 && al == el - 1));
          if (!ok && !bad) begin
            bad = 1'b1;
            ba = (k < rec_n) ? rec_lvl[k] * 10000 + al : -1;
            be = exp_lvl[k] * 10000 + el;
          end
        end
      end
      if (present) chk(!bad, tag(r), "level*10000+width", ba, be);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input int i, input int scale);
    build(i);
    rec_n = 0; done_cnt = 0;
    ifr_type = V_IFR[i];
    for (int j = 0; j < V_NM[i]; j++)
      send(V_MAIN[i][31-8*j -: 8], j == V_NM[i] - 1);
    for (int j = 0; j < V_NR[i]; j++)
      send(V_RESP[i][15-8*j -: 8], j == V_NR[i] - 1);
    chk(in_ready == 1'b0, "R7", "ready after final byte", int'(in_ready), 0);
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "ready after frame end", int'(in_ready), 1);
    chk(lost_arb == 1'b0, "R8", "no loss with echoed line", int'(lost_arb), 0);
    compare(scale);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_out == 1'b0, "R1", "bus_out", int'(bus_out), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    chk(done == 1'b0 && lost_arb == 1'b0, "R1", "done|lost", int'(done | lost_arb), 0);

    // table of frames
    for (int i = 0; i < NV; i++) run_vec(i, 1);

    // R8 contention during first passive bit of a 0x00 frame
    rec_n = 0; done_cnt = 0; ifr_type = 2'd0;
    send(8'h00, 1'b1);
    repeat (210) @(negedge clk);
    contend = 1'b1;
    repeat (100) @(negedge clk);
    chk(lost_arb == 1'b1, "R8", "lost flag", int'(lost_arb), 1);
    chk(bus_out == 1'b0, "R8", "released line", int'(bus_out), 0);
    chk(in_ready == 1'b1, "R8", "back to idle", int'(in_ready), 1);
    contend = 1'b0;
    repeat (600) @(negedge clk);
    chk(done_cnt == 0, "R8", "no done after loss", done_cnt, 0);
    chk(lost_arb == 1'b1, "R8", "flag held", int'(lost_arb), 1);
    run_vec(0, 1);
    chk(lost_arb == 1'b0, "R8", "flag cleared by new frame", int'(lost_arb), 0);

    // R9 tick every other cycle doubles every width
    tick_half = 1'b1;
    run_vec(1, 2);
    tick_half = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule